// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt requests of a 16550-style serial port, masks each one with a software-written enable register, and ranks the survivors by a fixed priority. The result is a read-only identification word and one interrupt line to the processor. Software reads the word after an interrupt to learn which source needs service. Bit 0 of the word is an active-low "something pending" flag. Bits 3..1 carry the code of the highest-priority pending source. Bits 9 and 8 carry two sticky auto-baud status flags.

Three sources are level conditions held by the serial core: line status, receive data available and character timeout. Each stays requested for as long as the core holds it. Transmit-holding-empty, CTS change and the two auto-baud events arrive as one-cycle pulses, and the block latches them. A read of the identification word freezes the reported value for the read cycle. An event that lands during the read is latched and shows on a later read. A read that reports transmit-holding-empty also acknowledges it. The CTS-change flag is acknowledged by a separate modem-status read strobe, and each auto-baud flag by a write-one-to-clear strobe.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification word is 0x001, the interrupt output is 0 and the enable readback is 0.
- R2: Bit 0 of the identification word is 0 when at least one enabled source is pending and 1 when none is. When it is 1, bits 3..1 read 000.
- R3: Bits 3..1 report the highest-priority pending enabled source. Line status reports 011, receive data 010, character timeout 110, transmit-holding-empty 001 and modem status 000, in that order of priority from highest to lowest. Bits 7..4 read 0.
- R4: Enable bit 0 gates receive data and character timeout. Enable bit 1 gates transmit-holding-empty and enable bit 2 gates line status. A disabled source is not reported.
- R5: With auto-CTS mode off, a CTS-change pulse sets the modem-status source when enable bit 3 is set, and has no effect when it is clear.
- R6: With auto-CTS mode on, a CTS-change pulse sets the modem-status source only when both enable bit 3 and enable bit 7 are set.
- R7: An auto-baud-end pulse sets identification bit 8 when enable bit 8 is set. An auto-baud-timeout pulse sets bit 9 when enable bit 9 is set. The bits stay set until the matching clear strobe: bit 0 of the clear strobe clears bit 8, and bit 1 clears bit 9. These bits never change bits 3..0.
- R8: Enable bits 31..10 ignore writes and read back as 0. Bits 9..0 read back what was written.
- R9: In a cycle with the read strobe high, the identification word does not change at the clock edge. An event arriving during a read stays latched and appears after the read ends.
- R10: A read that reports transmit-holding-empty clears that source. The modem-status source clears on the modem-status read strobe.
- R11: The interrupt output is a register. It is 1 one cycle after any enabled prioritised source is pending, or after an auto-baud status bit is set while its enable bit is set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrite | input | 1 | Write strobe for the enable register |
| enWriteData | input | 32 | Enable register write data |
| enableOut | output | 32 | Enable register readback |
| lineStatus | input | 1 | Line status condition (level) |
| rxAvail | input | 1 | Receive data available condition (level) |
| charTimeout | input | 1 | Character timeout condition (level) |
| evTxEmpty | input | 1 | Transmit holding empty event pulse |
| evCtsChange | input | 1 | CTS transition event pulse |
| evAbEnd | input | 1 | Auto-baud end event pulse |
| evAbTimeout | input | 1 | Auto-baud timeout event pulse |
| autoCtsMode | input | 1 | Auto-CTS mode flag |
| idRead | input | 1 | Identification register read strobe |
| msrRead | input | 1 | Modem status read strobe |
| abClear | input | 2 | Write-one-to-clear strobes for status bits 8 and 9 |
| idWord | output | 10 | Identification word |
| irqOut | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is a new event that lands while a read is freezing the word, so that the frozen value and the live value differ. The bench first sets a modem-status request. It then holds the read strobe for two cycles and pulses transmit-holding-empty in the first of them. The word must still show the modem-status code after the second cycle, must switch to the higher-priority transmit code once the read ends, and must drop back to modem status after that code is read and acknowledged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // enable register field positions (behavioural: software writes these)
  localparam int ENW         = 10;
  localparam int EN_RX       = 0;
  localparam int EN_THRE     = 1;
  localparam int EN_LS       = 2;
  localparam int EN_MS       = 3;
  localparam int EN_CTSAUTO  = 7;
  localparam int EN_ABEND    = 8;
  localparam int EN_ABTO     = 9;

  // identification word layout
  localparam int IDW         = 10;
  localparam int CODEW       = 3;
  localparam int PADW        = IDW - CODEW - 3;

  // prioritised sources, index 0 is highest priority
  localparam int NSRC        = 5;
  localparam int SRC_LS      = 0;
  localparam int SRC_RX      = 1;
  localparam int SRC_CTO     = 2;
  localparam int SRC_THRE    = 3;
  localparam int SRC_MS      = 4;

  localparam logic [CODEW-1:0] CODE_LS   = 3'b011;
  localparam logic [CODEW-1:0] CODE_RX   = 3'b010;
  localparam logic [CODEW-1:0] CODE_CTO  = 3'b110;
  localparam logic [CODEW-1:0] CODE_THRE = 3'b001;
  localparam logic [CODEW-1:0] CODE_MS   = 3'b000;

  function automatic logic [CODEW-1:0] srcCode(input int idx);
    case (idx)
      SRC_LS:   return CODE_LS;
      SRC_RX:   return CODE_RX;
      SRC_CTO:  return CODE_CTO;
      SRC_THRE: return CODE_THRE;
      default:  return CODE_MS;
    endcase
  endfunction

  typedef struct packed {
    logic snapLoad;
    logic clrThre;
    logic clrMs;
    logic clrAbEnd;
    logic clrAbTo;
  } strobeT;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             idRead,
  input  logic             msrRead,
  input  logic [1:0]       abClear,
  input  logic [CODEW-1:0] snapCode,
  input  logic             snapNone,
  output strobeT           strb
);

  logic reportingThre;

  assign reportingThre = !snapNone && (snapCode == CODE_THRE);

  always_comb begin
    strb          = '0;
    strb.snapLoad = !idRead;
    strb.clrThre  = idRead && reportingThre;
    strb.clrMs    = msrRead;
    strb.clrAbEnd = abClear[0];
    strb.clrAbTo  = abClear[1];
  end

  // R9: the reported word holds across a read edge
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    idRead |=> $stable({snapCode, snapNone}));

  // R2: an idle word carries the all-zero code
  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    snapNone |-> (snapCode == CODE_MS));

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int BUSW = 32
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWrite,
  input  logic [BUSW-1:0]  enWriteData,
  output logic [BUSW-1:0]  enableOut,
  input  logic             lineStatus,
  input  logic             rxAvail,
  input  logic             charTimeout,
  input  logic             evTxEmpty,
  input  logic             evCtsChange,
  input  logic             evAbEnd,
  input  logic             evAbTimeout,
  input  logic             autoCtsMode,
  input  strobeT           strb,
  output logic [IDW-1:0]   idWord,
  output logic             irqOut,
  output logic [CODEW-1:0] snapCode,
  output logic             snapNone
);

  localparam int RSVW = BUSW - ENW;
  localparam logic [IDW-1:0] ID_RESET = {{(IDW-1){1'b0}}, 1'b1};

  logic [ENW-1:0]   ierQ;
  logic             threPend, msPend, abEndSt, abToSt;
  logic             ctsGate;
  logic [NSRC-1:0]  srcReq;
  logic [CODEW-1:0] liveCode;
  logic             liveAny;
  logic             abIrq;
  logic [IDW-1:0]   liveWord, snapQ;
  logic             irqQ;

  // enable register: only the implemented bits are stored
  always_ff @(posedge clk) begin
    if (!rstN)        ierQ <= '0;
    else if (enWrite) ierQ <= enWriteData[ENW-1:0];
  end

  assign enableOut = {{RSVW{1'b0}}, ierQ};

  // CTS qualification depends on the auto-CTS mode
  assign ctsGate = ierQ[EN_MS] && (!autoCtsMode || ierQ[EN_CTSAUTO]);

  // latched event sources; a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      threPend <= 1'b0;
      msPend   <= 1'b0;
      abEndSt  <= 1'b0;
      abToSt   <= 1'b0;
    end else begin
      threPend <= (evTxEmpty   && ierQ[EN_THRE])  || (threPend && !strb.clrThre);
      msPend   <= (evCtsChange && ctsGate)        || (msPend   && !strb.clrMs);
      abEndSt  <= (evAbEnd     && ierQ[EN_ABEND]) || (abEndSt  && !strb.clrAbEnd);
      abToSt   <= (evAbTimeout && ierQ[EN_ABTO])  || (abToSt   && !strb.clrAbTo);
    end
  end

  // masked request vector in priority order
  always_comb begin
    srcReq           = '0;
    srcReq[SRC_LS]   = lineStatus  && ierQ[EN_LS];
    srcReq[SRC_RX]   = rxAvail     && ierQ[EN_RX];
    srcReq[SRC_CTO]  = charTimeout && ierQ[EN_RX];
    srcReq[SRC_THRE] = threPend    && ierQ[EN_THRE];
    srcReq[SRC_MS]   = msPend      && ierQ[EN_MS];
  end

  // fixed-priority pick: the lowest index that requests wins
  always_comb begin
    liveCode = CODE_MS;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (srcReq[i]) liveCode = srcCode(i);
    end
  end

  assign liveAny  = |srcReq;
  assign abIrq    = (abEndSt && ierQ[EN_ABEND]) || (abToSt && ierQ[EN_ABTO]);
  assign liveWord = {abToSt, abEndSt, {PADW{1'b0}}, liveCode, !liveAny};

  // snapshot presented to the bus, frozen while a read is in progress
  always_ff @(posedge clk) begin
    if (!rstN)              snapQ <= ID_RESET;
    else if (strb.snapLoad) snapQ <= liveWord;
  end

  // registered interrupt line
  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= liveAny || abIrq;
  end

  assign idWord   = snapQ;
  assign irqOut   = irqQ;
  assign snapCode = snapQ[CODEW:1];
  assign snapNone = snapQ[0];

  // R10: an acknowledged transmit-empty request drops unless re-raised
  assert_thre_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrThre && !evTxEmpty) |=> !threPend);

  // R10: modem-status request drops on its read strobe
  assert_ms_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMs && !evCtsChange) |=> !msPend);

  // R6: in auto-CTS mode without enable bit 7 a CTS edge cannot raise a request
  assert_autocts_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evCtsChange && autoCtsMode && !ierQ[EN_CTSAUTO] && !msPend) |=> !msPend);

  // R11: an enabled auto-baud flag drives the interrupt line next cycle
  assert_ab_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (abEndSt && ierQ[EN_ABEND]) |=> irqOut);

  // R7: a cleared auto-baud flag stays clear without a new event
  assert_ab_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAbEnd && !evAbEnd) |=> !abEndSt);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int BUSW = 32
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            enWrite,
  input  logic [BUSW-1:0] enWriteData,
  output logic [BUSW-1:0] enableOut,
  input  logic            lineStatus,
  input  logic            rxAvail,
  input  logic            charTimeout,
  input  logic            evTxEmpty,
  input  logic            evCtsChange,
  input  logic            evAbEnd,
  input  logic            evAbTimeout,
  input  logic            autoCtsMode,
  input  logic            idRead,
  input  logic            msrRead,
  input  logic [1:0]      abClear,
  output logic [IDW-1:0]  idWord,
  output logic            irqOut
);

  strobeT           strb;
  logic [CODEW-1:0] snapCode;
  logic             snapNone;

  uart_irq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .idRead   (idRead),
    .msrRead  (msrRead),
    .abClear  (abClear),
    .snapCode (snapCode),
    .snapNone (snapNone),
    .strb     (strb)
  );

  uart_irq_datapath #(.BUSW(BUSW)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .enWrite     (enWrite),
    .enWriteData (enWriteData),
    .enableOut   (enableOut),
    .lineStatus  (lineStatus),
    .rxAvail     (rxAvail),
    .charTimeout (charTimeout),
    .evTxEmpty   (evTxEmpty),
    .evCtsChange (evCtsChange),
    .evAbEnd     (evAbEnd),
    .evAbTimeout (evAbTimeout),
    .autoCtsMode (autoCtsMode),
    .strb        (strb),
    .idWord      (idWord),
    .irqOut      (irqOut),
    .snapCode    (snapCode),
    .snapNone    (snapNone)
  );

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enWrite;
  logic [31:0] enWriteData;
  logic [31:0] enableOut;
  logic        lineStatus, rxAvail, charTimeout;
  logic        evTxEmpty, evCtsChange, evAbEnd, evAbTimeout;
  logic        autoCtsMode, idRead, msrRead;
  logic [1:0]  abClear;
  logic [9:0]  idWord;
  logic        irqOut;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enWriteData(enWriteData),
    .enableOut(enableOut), .lineStatus(lineStatus), .rxAvail(rxAvail),
    .charTimeout(charTimeout), .evTxEmpty(evTxEmpty), .evCtsChange(evCtsChange),
    .evAbEnd(evAbEnd), .evAbTimeout(evAbTimeout), .autoCtsMode(autoCtsMode),
    .idRead(idRead), .msrRead(msrRead), .abClear(abClear),
    .idWord(idWord), .irqOut(irqOut)
  );

  // {enable[3:0], ls, rx, cto, expected idWord[3:0], expected irq}
  localparam logic [11:0] VEC [0:8] = '{
    12'b1111_111_0110_1,
    12'b1111_011_0100_1,
    12'b1111_001_1100_1,
    12'b1011_100_0001_0,
    12'b1011_110_0100_1,
    12'b1110_011_0001_0,
    12'b1110_111_0110_1,
    12'b0000_111_0001_0,
    12'b0100_100_0110_1
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setIer(input logic [31:0] v);
    enWrite = 1'b1; enWriteData = v;
    tick();
    enWrite = 1'b0;
  endtask

  task automatic pulseCts();
    evCtsChange = 1'b1; tick(); evCtsChange = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enWrite = 1'b0; enWriteData = '0;
    lineStatus = 0; rxAvail = 0; charTimeout = 0;
    evTxEmpty = 0; evCtsChange = 0; evAbEnd = 0; evAbTimeout = 0;
    autoCtsMode = 0; idRead = 0; msrRead = 0; abClear = 2'b00;
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 idWord", {22'b0, idWord}, 32'h001);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R1 enableOut", enableOut, 32'h0);

    // R3 R4 R11 table of level-source patterns
    for (int i = 0; i < 9; i++) begin
      enWrite = 1'b1; enWriteData = {28'b0, VEC[i][11:8]};
      lineStatus = VEC[i][7]; rxAvail = VEC[i][6]; charTimeout = VEC[i][5];
      tick();
      enWrite = 1'b0;
      tick();
      chk("R3/R4 idWord nibble", {28'b0, idWord[3:0]}, {28'b0, VEC[i][4:1]});
      chk("R11 irqOut", {31'b0, irqOut}, {31'b0, VEC[i][0]});
      chk("R3 pad bits", {28'b0, idWord[7:4]}, 32'h0);
    end
    lineStatus = 0; rxAvail = 0; charTimeout = 0;
    setIer(32'h0); tick();

    // R8 reserved enable bits
    setIer(32'hFFFF_FFFF);
    chk("R8 enable readback", enableOut, 32'h0000_03FF);
    setIer(32'h0); tick();

    // R4 disabled transmit-empty is not reported
    evTxEmpty = 1'b1; tick(); evTxEmpty = 1'b0; tick();
    chk("R4 thre masked", {22'b0, idWord}, 32'h001);

    // R5 CTS with enable bit 3 clear, auto-CTS off
    pulseCts(); tick();
    chk("R5 cts masked", {22'b0, idWord}, 32'h001);

    // R5 CTS with enable bit 3, then R9 freeze with event during read
    setIer(32'h0A); tick();
    pulseCts(); tick();
    chk("R5 modem status", {28'b0, idWord[3:0]}, 32'h0);
    chk("R2 pending irq", {31'b0, irqOut}, 32'h1);
    idRead = 1'b1; evTxEmpty = 1'b1;
    tick();
    evTxEmpty = 1'b0;
    tick();
    idRead = 1'b0;
    chk("R9 frozen during read", {28'b0, idWord[3:0]}, 32'h0);
    tick();
    chk("R9 held event shows", {28'b0, idWord[3:0]}, 32'h2);

    // R10 reading the transmit-empty code acknowledges it
    idRead = 1'b1; tick(); idRead = 1'b0;
    chk("R9 frozen at read", {28'b0, idWord[3:0]}, 32'h2);
    tick();
    chk("R10 thre cleared", {28'b0, idWord[3:0]}, 32'h0);
    msrRead = 1'b1; tick(); msrRead = 1'b0;
    tick();
    chk("R10 ms cleared", {22'b0, idWord}, 32'h001);
    chk("R11 irq low", {31'b0, irqOut}, 32'h0);

    // R6 auto-CTS gating
    autoCtsMode = 1'b1;
    setIer(32'h08); tick();
    pulseCts(); tick();
    chk("R6 bit7 missing", {22'b0, idWord}, 32'h001);
    setIer(32'h88); tick();
    pulseCts(); tick();
    chk("R6 both bits", {28'b0, idWord[3:0]}, 32'h0);
    msrRead = 1'b1; tick(); msrRead = 1'b0; tick();
    autoCtsMode = 1'b0;

    // R7 auto-baud status
    setIer(32'h100); tick();
    evAbEnd = 1'b1; tick(); evAbEnd = 1'b0; tick();
    chk("R7 ab end set", {22'b0, idWord}, 32'h101);
    chk("R11 ab irq", {31'b0, irqOut}, 32'h1);
    evAbTimeout = 1'b1; tick(); evAbTimeout = 1'b0; tick();
    chk("R7 ab timeout masked", {31'b0, idWord[9]}, 32'h0);
    abClear = 2'b01; tick(); abClear = 2'b00; tick();
    chk("R7 ab cleared", {22'b0, idWord}, 32'h001);
    chk("R11 irq after clear", {31'b0, irqOut}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule